// File: doc/BRIEF.md
# Sequential 64-Point Number-Theoretic Transform over Z/257

This block evaluates a 64-point number-theoretic transform whose coefficients are residues modulo 257. It uses the primitive 64th root of unity 46. The 64 inputs sit in an 8×8 register matrix. A single combinational 8-point butterfly network is swept down the rows twice. The first sweep is followed by a per-element twiddle multiply by powers of 46. A one-cycle transpose separates the two sweeps.

A caller writes the matrix one row of eight residues at a time while the block is idle, then pulses start. The inputs are expected in transposed order: row r holds the samples r, r+8, …, r+56. After the second sweep the register holds the spectrum, and the output bus presents it in natural index order. A mode input, sampled at start, scales output m by 139^m. This lets two instances form the odd and even halves of a 128-point transform, where 139 is the matching 128th root of unity.

Top module: `ntt64_seq`

## Requirements
- R1: Every arithmetic result is reduced modulo 257. With all inputs below 257, every matrix element and every output slot stays below 257.
- R2: While the block is idle and start_i is low, ld_en_i writes the row ld_row_i. Bits [9c+8:9c] of ld_data_i carry sample x[ld_row_i + 8c], for c = 0..7. A later write to the same row replaces the earlier one.
- R3: With odd_half_i low at start, output slot m (bits [9m+8:9m] of coef_o) equals the sum over n of x[n]·46^(n·m) mod 257, for m = 0..63.
- R4: With odd_half_i high at start, output slot m equals 139^m times the R3 value, mod 257.
- R5: The rising edge that samples start_i while idle raises busy_o for the next cycle. done_o rises on the 17th rising edge after that one, with busy_o low from then on. done_o and busy_o are never high together.
- R6: While busy_o is high, start_i and ld_en_i are ignored. The run completes at the same edge and yields the same result as an undisturbed run.
- R7: Once high, done_o and coef_o hold their values until the next accepted load or start. An accepted load clears done_o.
- R8: After reset, busy_o and done_o are low and every output slot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en_i | input | 1 | Write one matrix row |
| ld_row_i | input | 3 | Row index to write |
| ld_data_i | input | 72 | Eight 9-bit residues, lane c at bits [9c+8:9c] |
| start_i | input | 1 | Begin a transform (idle only) |
| odd_half_i | input | 1 | Apply the 139^m output scaling |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | Result valid on coef_o |
| coef_o | output | 576 | Result, slot m at bits [9m+8:9m] |

## Verification
The block has a single build, since its widths, roots and matrix shape are fixed by the modulus. The bench uses the default package constants: 9-bit residues in an 8×8 matrix. Under that build, the bench computes an O(n²) evaluation of the 64-point sum and compares every one of the 64 slots against it. It does this for impulses, for an all-256 input that drives every lane to the largest residue, for random vectors, and in both scaling modes. Row overwrite before start is exercised, along with loads and restarts injected mid-run. The bench also checks the exact start-to-done edge count and confirms that the result holds afterwards.

// File: rtl/ntt64_pkg.sv
// Shared constants, phase type and modulo-257 helpers for the 64-point transform.
// Assumes every operand handed to the helpers is already a residue below 257.
package ntt64_pkg;
    localparam int MODQ     = 257;
    localparam int RES_W    = 9;
    localparam int DIM      = 8;
    localparam int NPTS     = DIM * DIM;
    localparam int IDX_W    = $clog2(DIM);
    localparam int STAGES   = $clog2(DIM);
    localparam int OMEGA64  = 46;
    localparam int OMEGA128 = 139;
    localparam int LAT      = 2 * DIM + 1;

    typedef enum logic [1:0] {PH_IDLE, PH_ROW1, PH_XPOSE, PH_ROW2} phase_e;

    function automatic logic [RES_W-1:0] mod_add(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b);
        logic [RES_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (RES_W+1)'(MODQ)) s = s - (RES_W+1)'(MODQ);
        return s[RES_W-1:0];
    endfunction

    function automatic logic [RES_W-1:0] mod_sub(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b);
        logic [RES_W:0] d;
        d = {1'b0, a} + (RES_W+1)'(MODQ) - {1'b0, b};
        if (d >= (RES_W+1)'(MODQ)) d = d - (RES_W+1)'(MODQ);
        return d[RES_W-1:0];
    endfunction

    // Product split as hi*256 + lo, folded with 256 = -1 (mod 257).
    function automatic logic [RES_W-1:0] mod_mul(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b);
        logic [2*RES_W-1:0] p;
        logic [RES_W:0]     r;
        p = (2*RES_W)'(a) * (2*RES_W)'(b);
        r = (RES_W+1)'(p[7:0]) + (RES_W+1)'(MODQ) - p[2*RES_W-1:8];
        if (r >= (RES_W+1)'(MODQ)) r = r - (RES_W+1)'(MODQ);
        return r[RES_W-1:0];
    endfunction

    function automatic logic [RES_W-1:0] pow_mod(input int base, input int e);
        int r;
        r = 1;
        for (int i = 0; i < e; i++) r = (r * base) % MODQ;
        return RES_W'(r);
    endfunction

    function automatic int bitrev(input int v, input int w);
        int r;
        r = 0;
        for (int i = 0; i < w; i++) r = (r << 1) | ((v >> i) & 1);
        return r;
    endfunction
endpackage

// File: rtl/ntt64_bfly8.sv
// Combinational 8-point transform: three radix-2 decimation-in-frequency layers
// with root 46^8 = 4, output reordered from bit-reversed to natural index.
// Assumes inputs are residues below 257.
module ntt64_bfly8
    import ntt64_pkg::*;
(
    input  logic [RES_W-1:0] x_i [DIM],
    output logic [RES_W-1:0] y_o [DIM]
);
    localparam int ROOT8 = int'(pow_mod(OMEGA64, NPTS / DIM));

    logic [RES_W-1:0] st [STAGES+1][DIM];

    for (genvar p = 0; p < DIM; p++) begin : g_in
        assign st[0][p] = x_i[p];
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_layer
        localparam int H = DIM >> (s + 1);
        for (genvar p = 0; p < DIM; p++) begin : g_lane
            if ((p & H) == 0) begin : g_sum
                // upper leg of a butterfly: plain sum
                assign st[s+1][p] = mod_add(st[s][p], st[s][p+H]);
            end else begin : g_diff
                // lower leg: difference times the layer twiddle
                localparam logic [RES_W-1:0] TW = pow_mod(ROOT8, (p % H) * (DIM / (2 * H)));
                assign st[s+1][p] = mod_mul(mod_sub(st[s][p-H], st[s][p]), TW);
            end
        end
    end

    for (genvar k = 0; k < DIM; k++) begin : g_out
        localparam int BR = bitrev(k, IDX_W);
        assign y_o[k] = st[STAGES][BR];
    end
endmodule

// File: rtl/ntt64_twiddle.sv
// Lane multiplier bank. First sweep scales lane c of row r by 46^(r*c); second
// sweep scales by 139^(8c+r) when the odd-half mode is set, else passes through.
// Assumes residues below 257 on every lane.
module ntt64_twiddle
    import ntt64_pkg::*;
(
    input  logic             pass2_i,
    input  logic             odd_i,
    input  logic [IDX_W-1:0] row_i,
    input  logic [RES_W-1:0] d_i [DIM],
    output logic [RES_W-1:0] q_o [DIM]
);
    logic [RES_W-1:0] t1 [DIM][DIM];
    logic [RES_W-1:0] t2 [DIM][DIM];

    for (genvar c = 0; c < DIM; c++) begin : g_lane
        for (genvar r = 0; r < DIM; r++) begin : g_tab
            assign t1[c][r] = pow_mod(OMEGA64, r * c);
            assign t2[c][r] = pow_mod(OMEGA128, DIM * c + r);
        end

        logic [RES_W-1:0] fac;
        // pick this lane's factor for the current sweep and row, then multiply
        always_comb begin
            if (!pass2_i)   fac = t1[c][row_i];
            else if (odd_i) fac = t2[c][row_i];
            else            fac = RES_W'(1);
            q_o[c] = mod_mul(d_i[c], fac);
        end
    end
endmodule

// File: rtl/ntt64_ctrl.sv
// Sequencer: idle -> 8 first-sweep rows -> transpose -> 8 second-sweep rows -> idle.
// Assumes start_i is ignored outside idle; latches the scaling mode at start.
module ntt64_ctrl
    import ntt64_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ld_en_i,
    input  logic             odd_half_i,
    output logic [IDX_W-1:0] row_o,
    output logic             upd_o,
    output logic             pass2_o,
    output logic             xpose_o,
    output logic             odd_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int CNT_W = $clog2(LAT + 2);

    phase_e           phase_q;
    logic [IDX_W-1:0] row_q;
    logic             odd_q, done_q;
    logic             last_row;

    assign last_row = (row_q == IDX_W'(DIM - 1));

    // phase, row index, mode latch and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            row_q   <= '0;
            odd_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_ROW1;
                        row_q   <= '0;
                        odd_q   <= odd_half_i;
                        done_q  <= 1'b0;
                    end else if (ld_en_i) begin
                        done_q  <= 1'b0;
                    end
                end
                PH_ROW1: begin
                    row_q <= row_q + 1'b1;
                    if (last_row) phase_q <= PH_XPOSE;
                end
                PH_XPOSE: begin
                    row_q   <= '0;
                    phase_q <= PH_ROW2;
                end
                default: begin
                    row_q <= row_q + 1'b1;
                    if (last_row) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign row_o   = row_q;
    assign upd_o   = (phase_q == PH_ROW1) || (phase_q == PH_ROW2);
    assign pass2_o = (phase_q == PH_ROW2);
    assign xpose_o = (phase_q == PH_XPOSE);
    assign odd_o   = odd_q;
    assign busy_o  = (phase_q != PH_IDLE);
    assign done_o  = done_q;

    // checker: edges elapsed since the accepted start
    logic [CNT_W-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                           since_q <= '0;
        else if (phase_q == PH_IDLE && start_i) since_q <= '0;
        else if (busy_o)                      since_q <= since_q + 1'b1;
    end

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> since_q == CNT_W'(LAT));
    assert_busy_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    assert_done_excl_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !(phase_q == PH_ROW1 && row_q == '0));
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_o) && !$past(start_i) && !$past(ld_en_i)) |-> done_o);
endmodule

// File: rtl/ntt64_seq.sv
// Top: 8x8 residue matrix with row loading, one shared butterfly network and
// twiddle bank, in-place transpose, and natural-order output bus.
// Assumes loaded residues are below 257 and rows are loaded in transposed order.
module ntt64_seq
    import ntt64_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_en_i,
    input  logic [IDX_W-1:0]      ld_row_i,
    input  logic [DIM*RES_W-1:0]  ld_data_i,
    input  logic                  start_i,
    input  logic                  odd_half_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [NPTS*RES_W-1:0] coef_o
);
    logic [RES_W-1:0] mat_q  [DIM][DIM];
    logic [RES_W-1:0] ld_lane [DIM];
    logic [RES_W-1:0] bf_out [DIM];
    logic [RES_W-1:0] tw_out [DIM];
    logic [IDX_W-1:0] row;
    logic             upd, pass2, xpose, odd, load_acc;

    ntt64_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ld_en_i(load_acc),
        .odd_half_i(odd_half_i), .row_o(row), .upd_o(upd), .pass2_o(pass2),
        .xpose_o(xpose), .odd_o(odd), .busy_o(busy_o), .done_o(done_o)
    );

    ntt64_bfly8 u_bfly (.x_i(mat_q[row]), .y_o(bf_out));

    ntt64_twiddle u_tw (
        .pass2_i(pass2), .odd_i(odd), .row_i(row), .d_i(bf_out), .q_o(tw_out)
    );

    assign load_acc = ld_en_i && !busy_o && !start_i;

    for (genvar c = 0; c < DIM; c++) begin : g_lane
        assign ld_lane[c] = ld_data_i[c*RES_W +: RES_W];
    end

    // matrix update: load a row, write back a processed row, or transpose
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++) mat_q[r][c] <= '0;
        end else if (load_acc) begin
            mat_q[ld_row_i] <= ld_lane;
        end else if (upd) begin
            mat_q[row] <= tw_out;
        end else if (xpose) begin
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++) mat_q[r][c] <= mat_q[c][r];
        end
    end

    // row k2, column k1 holds spectrum index 8*k1 + k2
    for (genvar r = 0; r < DIM; r++) begin : g_orow
        for (genvar c = 0; c < DIM; c++) begin : g_ocol
            assign coef_o[(c*DIM + r)*RES_W +: RES_W] = mat_q[r][c];
            assert_residue_R1: assert property (@(posedge clk) disable iff (!rst_n)
                mat_q[r][c] < RES_W'(MODQ));
        end
    end

    for (genvar c = 0; c < DIM; c++) begin : g_twchk
        assert_twiddle_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            upd |-> tw_out[c] < RES_W'(MODQ));
    end
endmodule

// File: tb/ntt64_seq_tb.sv
// Directed bench for ntt64_seq: each task drives one scenario and checks it
// against a direct O(n^2) modulo-257 evaluation computed here.
module ntt64_seq_tb_top;
    import ntt64_pkg::RES_W;
    import ntt64_pkg::DIM;
    import ntt64_pkg::NPTS;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  ld_en = 1'b0;
    logic [2:0]            ld_row = '0;
    logic [DIM*RES_W-1:0]  ld_data = '0;
    logic                  start = 1'b0;
    logic                  odd_half = 1'b0;
    logic                  busy, done;
    logic [NPTS*RES_W-1:0] coef;

    int n_chk = 0;
    int n_bad = 0;
    int xin [NPTS];
    int expv [NPTS];

    always #5 clk = ~clk;

    ntt64_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en_i(ld_en), .ld_row_i(ld_row),
        .ld_data_i(ld_data), .start_i(start), .odd_half_i(odd_half),
        .busy_o(busy), .done_o(done), .coef_o(coef)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_val);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_val);
        end
    endtask

    function automatic int pw(input int b, input int e);
        int r = 1;
        for (int i = 0; i < e; i++) r = (r * b) % 257;
        return r;
    endfunction

    // direct evaluation, optionally scaled by 139^m
    task automatic make_ref(input bit oddm);
        for (int m = 0; m < NPTS; m++) begin
            int acc = 0;
            int p = 1;
            int wm = pw(46, m);
            for (int n = 0; n < NPTS; n++) begin
                acc = (acc + xin[n] * p) % 257;
                p = (p * wm) % 257;
            end
            if (oddm) acc = (acc * pw(139, m)) % 257;
            expv[m] = acc;
        end
    endtask

    task automatic load_row(input int r);
        @(negedge clk);
        ld_en = 1'b1;
        ld_row = 3'(r);
        for (int c = 0; c < DIM; c++) ld_data[c*RES_W +: RES_W] = RES_W'(xin[r + DIM*c]);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all();
        for (int r = 0; r < DIM; r++) load_row(r);
    endtask

    task automatic cmp_all(input string req);
        for (int m = 0; m < NPTS; m++)
            chk(int'(coef[m*RES_W +: RES_W]) == expv[m], req, int'(coef[m*RES_W +: RES_W]), expv[m]);
    endtask

    // start, optionally disturb mid-run, wait for done, check timing and result
    task automatic run(input bit oddm, input bit disturb, input string req);
        int cnt;
        make_ref(oddm);
        @(negedge clk);
        odd_half = oddm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        odd_half = 1'b0;
        cnt = 1;
        chk(busy == 1'b1, "R5 busy after start", int'(busy), 1);
        while (!done && cnt < 60) begin
            @(negedge clk);
            cnt++;
            if (disturb && cnt == 3) begin
                ld_en = 1'b1; ld_row = 3'd2; ld_data = {DIM{9'h0AA}};
            end
            if (disturb && cnt == 4) ld_en = 1'b0;
            if (disturb && cnt == 5) begin start = 1'b1; odd_half = ~oddm; end
            if (disturb && cnt == 6) begin start = 1'b0; odd_half = 1'b0; end
        end
        chk(cnt == 18, "R5 done latency", cnt, 18);
        chk(busy == 1'b0, "R5 busy low at done", int'(busy), 0);
        cmp_all(req);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R8 busy", int'(busy), 0);
        chk(done == 1'b0, "R8 done", int'(done), 0);
        for (int m = 0; m < NPTS; m++)
            chk(coef[m*RES_W +: RES_W] == '0, "R8 coef zero", int'(coef[m*RES_W +: RES_W]), 0);
    endtask

    task automatic t_impulse(input int pos, input bit oddm);
        for (int n = 0; n < NPTS; n++) xin[n] = (n == pos) ? 1 : 0;
        load_all();
        run(oddm, 1'b0, oddm ? "R4 impulse" : "R3 impulse");
    endtask

    task automatic t_max();
        for (int n = 0; n < NPTS; n++) xin[n] = 256;
        load_all();
        run(1'b0, 1'b0, "R1 all-256");
    endtask

    task automatic t_random(input bit oddm);
        for (int n = 0; n < NPTS; n++) xin[n] = int'($urandom % 257);
        load_all();
        run(oddm, 1'b0, oddm ? "R4 random" : "R3 random");
    endtask

    task automatic t_overwrite();
        for (int n = 0; n < NPTS; n++) xin[n] = 7;
        load_all();
        for (int n = 0; n < NPTS; n++) xin[n] = (n % DIM == 2) ? (n + 30) : 7;
        load_row(2);
        run(1'b0, 1'b0, "R2 row overwrite");
    endtask

    task automatic t_disturb();
        for (int n = 0; n < NPTS; n++) xin[n] = int'($urandom % 257);
        load_all();
        run(1'b0, 1'b1, "R6 ignored mid-run");
    endtask

    task automatic t_hold();
        for (int n = 0; n < NPTS; n++) xin[n] = (3 * n + 1) % 257;
        load_all();
        run(1'b1, 1'b0, "R4 hold setup");
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R7 done held", int'(done), 1);
        cmp_all("R7 coef held");
        load_row(0);
        chk(done == 1'b0, "R7 done cleared by load", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_impulse(0, 1'b0);
        t_impulse(1, 1'b0);
        t_impulse(0, 1'b1);
        t_max();
        t_random(1'b0);
        t_random(1'b0);
        t_random(1'b1);
        t_overwrite();
        t_disturb();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule